// File: doc/BRIEF.md
# I2C Synthesizer Register Slave

This block is the write-only control port of a fractional-N frequency synthesizer. A system clock samples the two-wire bus lines SCL and SDA. The block finds START and STOP conditions and compares the first byte of each transfer with a 7-bit device address. Two of the address bits come from a board strap, so four of these devices can share one bus. After a matching address, the block accepts up to six data bytes: three divider bytes that carry the 15-bit scaling word and the reference-ratio select, and three control bytes that carry the charge-pump, tuning-amplifier, doubler, test and switch settings.

The block acknowledges each byte it accepts by pulling SDA low through the ninth clock. It keeps every accepted byte in a staging copy. The live outputs change only when the transfer ends with a STOP, and a one-cycle `commit` strobe marks that moment. Bytes must arrive in a strict order. A byte that breaks the order is not acknowledged, and the whole transfer is then thrown away. A sticky `word_valid` flag reports that all three parts of the scaling word have been loaded at least once. The downstream divider uses this flag to leave its reset.

The block has no data stream, so it has no valid/ready pair. Every output is a plain level held in a register, except `commit`, which is a pulse. Read transfers and clock stretching are not supported.

Top module: `synth_i2c_regs`

## Requirements
- R1: The address byte (MSB first) must equal 1,1,0,0,0,addr_sel[1],addr_sel[0],0 to be acknowledged. Any other address byte gets no acknowledge, and the block ignores the bus until the next START.
- R2: For each accepted byte the block asserts `sda_oe` from the SCL fall after the eighth bit until the SCL fall after the ninth pulse. `sda_oe` changes only while SCL is low.
- R3: The output registers `scale_word`, `ref_sel`, the control outputs and `sw_out` never change while a transfer is still open. They change only in the cycle in which `commit` is high.
- R4: The fields of the divider bytes are mapped as follows. Divider byte 1: bits 6:5 go to `ref_sel[1:0]` and bits 2:0 go to `scale_word[14:12]`. Divider byte 2: bits 5:0 go to `scale_word[11:6]`. Divider byte 3: bits 5:0 go to `scale_word[5:0]`.
- R5: The fields of control byte 1 are mapped as follows: bit 4 to `tune_off`, bit 3 to `test_mon`, bit 2 to `pump_off`, and bits 1:0 to `pump_cur[1:0]`.
- R6: The fields of control byte 2 are mapped as follows: bit 7 to `dbl_off`, bit 6 to `dbl_boost`, and bits 5:0 to `sw_out[5:0]`.
- R7: Bit 7 of the first data byte selects the register. A 0 makes it divider byte 1 and a 1 makes it control byte 1. After that, bytes follow the fixed sequence divider 1, divider 2, divider 3, control 1, control 2, control 3.
- R8: In three cases a byte is not acknowledged: a byte in the control-1 position that follows divider byte 3 with bit 7 = 0, a control-3 byte with any of bits 6:0 set, and any byte after control byte 3.
- R9: After a byte that is not acknowledged, no byte of that transfer is applied and no `commit` occurs.
- R10: A STOP applies exactly the bytes that the transfer delivered, even a partial sequence. Fields whose bytes were not sent keep their values.
- R11: `word_valid` is 0 after reset. It is set together with the `commit` by which all three divider bytes have each been applied at least once, possibly over several transfers. It then stays set.
- R12: During and after reset, all outputs, including `sda_oe`, `commit` and `word_valid`, are 0.
- R13: `commit` is a single-cycle pulse issued after a STOP that ends a transfer in which at least one data byte was accepted. At most one pulse is issued per transfer.
- R14: A repeated START throws away every byte staged since the previous START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Strap that sets address bits 2:1 |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| scale_word | output | 15 | Effective main-divider scaling word |
| ref_sel | output | 2 | Reference-ratio select |
| tune_off | output | 1 | Switches the tuning amplifier off |
| test_mon | output | 1 | Routes divider monitors to switch pins |
| pump_off | output | 1 | Switches the charge pump off |
| pump_cur | output | 2 | Charge-pump current code |
| dbl_off | output | 1 | Switches the reference doubler off |
| dbl_boost | output | 1 | Doubles the doubler output current |
| sw_out | output | 6 | Switch outputs |
| word_valid | output | 1 | All three divider bytes loaded at least once |
| commit | output | 1 | One-cycle strobe when new settings take effect |

## Verification
Full six-byte transfers show that every field lands in its own output bit. Transfers that start with a control byte tell the bit-7 register selection apart from positional decoding. Partial transfers ended by STOP or cut off by a repeated START separate "apply what was sent" from "apply nothing". Directed illegal sequences cover the three rejection rules and confirm that the earlier good bytes of a rejected transfer are also dropped. A seeded random mix of strap values, corrupted addresses, lengths and flipped bits then compares acknowledges, outputs and commit counts with a byte-level model.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 15;
  localparam int SLOT_N = 6;

  typedef enum logic [2:0] {
    POS_FIRST, POS_D2, POS_D3, POS_C1, POS_C2, POS_C3, POS_END
  } pos_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_BITS, RX_DECIDE, RX_ACK_WAIT, RX_ACK
  } rx_state_t;

  typedef struct packed {
    logic       tune_off;
    logic       test_mon;
    logic       pump_off;
    logic [1:0] pump_cur;
  } ctl1_t;

  typedef struct packed {
    logic       dbl_off;
    logic       dbl_boost;
    logic [5:0] sw;
  } ctl2_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev, scl_now;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_in;
          sda_pipe[g] <= sda_in;
        end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
    end
  end

  assign scl_now = scl_pipe[SYNC_STAGES-1];
  assign sda_s   = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_now;
      sda_prev <= sda_s;
    end

  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign bus_start = scl_now & scl_prev & sda_prev & ~sda_s;
  assign bus_stop  = scl_now & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import synth_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              ack_ok,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_q,
  output logic              first_byte,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= RX_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      first_byte <= 1'b0;
    end else if (bus_start) begin
      state      <= RX_BITS;
      bit_cnt    <= '0;
      first_byte <= 1'b1;
    end else if (bus_stop) begin
      state <= RX_IDLE;
    end else begin
      case (state)
        RX_BITS:
          if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            if (bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              state   <= RX_DECIDE;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        RX_DECIDE:   state <= ack_ok ? RX_ACK_WAIT : RX_IDLE;
        RX_ACK_WAIT: if (scl_fall) state <= RX_ACK;
        RX_ACK:
          if (scl_fall) begin
            state      <= RX_BITS;
            first_byte <= 1'b0;
          end
        default: state <= RX_IDLE;
      endcase
    end

  assign byte_stb = (state == RX_DECIDE);
  assign byte_q   = shreg;
  assign sda_oe   = (state == RX_ACK);
endmodule

// File: rtl/synth_reg_decode.sv
module synth_reg_decode
  import synth_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic              first_byte,
  input  logic [1:0]        addr_sel,
  output logic              ack_ok,
  output logic [WORD_W-1:0] scale_word,
  output logic [1:0]        ref_sel,
  output ctl1_t             ctl1,
  output ctl2_t             ctl2,
  output logic              word_valid,
  output logic              commit
);
  localparam int S_D1 = 0, S_D2 = 1, S_D3 = 2, S_C1 = 3, S_C2 = 4, S_C3 = 5;
  localparam int HI_W = WORD_W - 12;

  pos_t              pos, pos_nxt;
  logic [SLOT_N-1:0] mask;
  logic [2:0]        done;
  logic [2:0]        slot;
  logic              legal, addr_hit;
  logic [WORD_W-1:0] stg_word;
  logic [1:0]        stg_ref;
  ctl1_t             stg_c1;
  ctl2_t             stg_c2;

  assign addr_hit = (byte_q == {ADDR_PREFIX, addr_sel, 1'b0});

  always_comb begin
    legal   = 1'b0;
    slot    = 3'(S_D1);
    pos_nxt = POS_END;
    case (pos)
      POS_FIRST: begin
        legal   = 1'b1;
        slot    = byte_q[7] ? 3'(S_C1) : 3'(S_D1);
        pos_nxt = byte_q[7] ? POS_C2 : POS_D2;
      end
      POS_D2: begin legal = 1'b1;      slot = 3'(S_D2); pos_nxt = POS_D3; end
      POS_D3: begin legal = 1'b1;      slot = 3'(S_D3); pos_nxt = POS_C1; end
      POS_C1: begin legal = byte_q[7]; slot = 3'(S_C1); pos_nxt = POS_C2; end
      POS_C2: begin legal = 1'b1;      slot = 3'(S_C2); pos_nxt = POS_C3; end
      POS_C3: begin
        legal   = (byte_q[6:0] == 7'd0);
        slot    = 3'(S_C3);
        pos_nxt = POS_END;
      end
      default: legal = 1'b0;
    endcase
  end

  assign ack_ok = first_byte ? addr_hit : legal;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos      <= POS_END;
      mask     <= '0;
      stg_word <= '0;
      stg_ref  <= '0;
      stg_c1   <= '0;
      stg_c2   <= '0;
    end else if (bus_start || bus_stop) begin
      mask <= '0;
      pos  <= POS_END;
    end else if (byte_stb) begin
      if (first_byte) begin
        if (addr_hit) pos <= POS_FIRST;
        mask <= '0;
      end else if (legal) begin
        pos        <= pos_nxt;
        mask[slot] <= 1'b1;
        case (int'(slot))
          S_D1: begin
            stg_ref                    <= byte_q[6:5];
            stg_word[WORD_W-1 -: HI_W] <= byte_q[HI_W-1:0];
          end
          S_D2: stg_word[11:6] <= byte_q[5:0];
          S_D3: stg_word[5:0]  <= byte_q[5:0];
          S_C1: stg_c1         <= ctl1_t'(byte_q[4:0]);
          S_C2: stg_c2         <= ctl2_t'(byte_q);
          default: ;
        endcase
      end else begin
        mask <= '0;
        pos  <= POS_END;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scale_word <= '0;
      ref_sel    <= '0;
      ctl1       <= '0;
      ctl2       <= '0;
      done       <= '0;
      commit     <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (bus_stop && (mask != '0)) begin
        commit <= 1'b1;
        done   <= done | mask[S_D3:S_D1];
        if (mask[S_D1]) begin
          ref_sel                      <= stg_ref;
          scale_word[WORD_W-1 -: HI_W] <= stg_word[WORD_W-1 -: HI_W];
        end
        if (mask[S_D2]) scale_word[11:6] <= stg_word[11:6];
        if (mask[S_D3]) scale_word[5:0]  <= stg_word[5:0];
        if (mask[S_C1]) ctl1 <= stg_c1;
        if (mask[S_C2]) ctl2 <= stg_c2;
      end
    end

  assign word_valid = &done;
endmodule

// File: rtl/synth_i2c_regs.sv
module synth_i2c_regs
  import synth_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b11000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [1:0]  addr_sel,
  output logic        sda_oe,
  output logic [14:0] scale_word,
  output logic [1:0]  ref_sel,
  output logic        tune_off,
  output logic        test_mon,
  output logic        pump_off,
  output logic [1:0]  pump_cur,
  output logic        dbl_off,
  output logic        dbl_boost,
  output logic [5:0]  sw_out,
  output logic        word_valid,
  output logic        commit
);
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic byte_stb, first_byte, ack_ok;
  logic [BYTE_W-1:0] byte_q;
  ctl1_t ctl1;
  ctl2_t ctl2;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_byte_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .ack_ok(ack_ok), .byte_stb(byte_stb), .byte_q(byte_q),
    .first_byte(first_byte), .sda_oe(sda_oe)
  );

  synth_reg_decode #(.ADDR_PREFIX(ADDR_PREFIX)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_stb(byte_stb), .byte_q(byte_q), .first_byte(first_byte),
    .addr_sel(addr_sel), .ack_ok(ack_ok), .scale_word(scale_word),
    .ref_sel(ref_sel), .ctl1(ctl1), .ctl2(ctl2),
    .word_valid(word_valid), .commit(commit)
  );

  assign {tune_off, test_mon, pump_off, pump_cur} = ctl1;
  assign {dbl_off, dbl_boost, sw_out}             = ctl2;
endmodule

// File: rtl/synth_i2c_regs_chk.sv
module synth_i2c_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_in,
  input logic        sda_oe,
  input logic [14:0] scale_word,
  input logic [5:0]  sw_out,
  input logic        word_valid,
  input logic        commit
);
  // R2: the acknowledge drive only moves while the bus clock is low
  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  // R3: the scaling word only moves together with commit
  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scale_word) |-> commit);

  // R3: the switch outputs only move together with commit
  p_sw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_out) |-> commit);

  // R13: commit lasts a single cycle
  p_commit_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R11: word_valid rises only together with a commit
  p_valid_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> commit);

  // R11: word_valid is sticky
  p_valid_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> word_valid);
endmodule

bind synth_i2c_regs synth_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .scale_word(scale_word), .sw_out(sw_out),
  .word_valid(word_valid), .commit(commit)
);

// File: tb/sim_synth_i2c_regs.sv
module sim_synth_i2c_regs;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic sda_oe, tune_off, test_mon, pump_off, dbl_off, dbl_boost, word_valid, commit;
  logic [14:0] scale_word;
  logic [1:0] ref_sel, pump_cur;
  logic [5:0] sw_out;
  wire sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_i2c_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_sel(strap), .sda_oe(sda_oe), .scale_word(scale_word),
    .ref_sel(ref_sel), .tune_off(tune_off), .test_mon(test_mon),
    .pump_off(pump_off), .pump_cur(pump_cur), .dbl_off(dbl_off),
    .dbl_boost(dbl_boost), .sw_out(sw_out), .word_valid(word_valid),
    .commit(commit)
  );

  int ncheck = 0, nbad = 0, ccount = 0;
  bit finished = 0;
  always @(posedge clk) if (commit) ccount <= ccount + 1;

  // model state
  logic [14:0] e_word = '0, s_word = '0;
  logic [1:0]  e_ref = '0, s_ref = '0;
  logic [4:0]  e_c1 = '0, s_c1 = '0;
  logic [7:0]  e_c2 = '0, s_c2 = '0;
  logic [2:0]  e_done = '0;
  logic [5:0]  m_mask = '0;
  int          m_pos = 0;
  logic [7:0]  xb [0:7];
  int          xn = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncheck++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit legal_at(input int p, input logic [7:0] b);
    case (p)
      0, 1, 2, 4: return 1'b1;
      3: return b[7];
      5: return b[6:0] == 7'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int slot_at(input int p, input logic [7:0] b);
    if (p == 0) return b[7] ? 3 : 0;
    return p;
  endfunction

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(QTR); scl_m = 1'b1; wq(QTR);
    sda_m = 1'b0; wq(QTR); scl_m = 1'b0; wq(QTR);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(QTR); scl_m = 1'b1; wq(QTR);
    sda_m = 1'b1; wq(2*QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(QTR); scl_m = 1'b1; wq(2*QTR); scl_m = 1'b0; wq(QTR);
    end
    sda_m = 1'b1; wq(QTR); scl_m = 1'b1; wq(QTR);
    acked = !sda_line; wq(QTR); scl_m = 1'b0; wq(QTR);
  endtask

  task automatic check_outs;
    chk("R4", {17'd0, ref_sel, scale_word}, {17'd0, e_ref, e_word});
    chk("R5", {27'd0, tune_off, test_mon, pump_off, pump_cur}, {27'd0, e_c1});
    chk("R6", {24'd0, dbl_off, dbl_boost, sw_out}, {24'd0, e_c2});
    chk("R11", {31'd0, word_valid}, {31'd0, &e_done});
  endtask

  task automatic finish_xfer;
    int c0;
    c0 = ccount;
    bus_stop();
    wq(12);
    if (m_mask != 0) begin
      if (m_mask[0]) begin e_ref = s_ref; e_word[14:12] = s_word[14:12]; end
      if (m_mask[1]) e_word[11:6] = s_word[11:6];
      if (m_mask[2]) e_word[5:0] = s_word[5:0];
      if (m_mask[3]) e_c1 = s_c1;
      if (m_mask[4]) e_c2 = s_c2;
      e_done = e_done | m_mask[2:0];
    end
    chk("R13", ccount - c0, (m_mask != 0) ? 1 : 0);
    m_mask = '0;
    check_outs();
  endtask

  task automatic run_xfer(input bit do_stop);
    bit got, e;
    bus_start();
    m_mask = '0;
    m_pos = 0;
    for (int k = 0; k < xn; k++) begin
      send_byte(xb[k], got);
      if (k == 0) begin
        e = (xb[0] == {5'b11000, strap, 1'b0});
        chk("R1", {31'd0, got}, {31'd0, e});
      end else begin
        e = legal_at(m_pos, xb[k]);
        chk(e ? "R2" : "R8", {31'd0, got}, {31'd0, e});
      end
      if (!e) begin m_mask = '0; break; end
      if (k > 0) begin
        case (slot_at(m_pos, xb[k]))
          0: begin s_ref = xb[k][6:5]; s_word[14:12] = xb[k][2:0]; end
          1: s_word[11:6] = xb[k][5:0];
          2: s_word[5:0] = xb[k][5:0];
          3: s_c1 = xb[k][4:0];
          4: s_c2 = xb[k];
          default: ;
        endcase
        m_mask[slot_at(m_pos, xb[k])] = 1'b1;
        m_pos = (m_pos == 0) ? (xb[k][7] ? 4 : 1) : m_pos + 1;
      end
    end
    if (do_stop) finish_xfer();
  endtask

  function automatic logic [7:0] gen_byte(input int idx);
    logic [7:0] r;
    r = 8'($urandom);
    case (idx)
      0: return {1'b0, r[6:0]};
      3: return {1'b1, r[6:0]};
      5: return {r[7], 7'd0};
      default: return r;
    endcase
  endfunction

  function automatic logic [7:0] addr_of(input logic [1:0] s);
    return {5'b11000, s, 1'b0};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    wq(5);
    // R12: reset values
    chk("R12", {14'd0, sda_oe, commit, word_valid, scale_word}, 32'd0);
    chk("R12", {19'd0, ref_sel, tune_off, test_mon, pump_off, pump_cur, dbl_off, dbl_boost, sw_out}, 32'd0);
    rst_n = 1'b1;
    wq(5);

    // R10: divider byte 1 alone, word_valid must stay low (R11)
    strap = 2'd1; xb[0] = addr_of(strap); xb[1] = 8'b0_10_00_101; xn = 2;
    run_xfer(1);
    chk("R10", {17'd0, scale_word}, 32'h5000);
    chk("R10", {30'd0, ref_sel}, 32'd2);
    chk("R11", {31'd0, word_valid}, 32'd0);

    // full sequence; R3 check before STOP
    strap = 2'd2; xb[0] = addr_of(strap);
    xb[1] = 8'h31; xb[2] = 8'h2A; xb[3] = 8'h15; xb[4] = 8'h9B; xb[5] = 8'hA5; xb[6] = 8'h80; xn = 7;
    run_xfer(0);
    chk("R3", {17'd0, scale_word}, 32'h5000);
    chk("R3", {26'd0, sw_out}, 32'd0);
    finish_xfer();
    chk("R4", {17'd0, scale_word}, 32'h1A95);
    chk("R5", {27'd0, tune_off, test_mon, pump_off, pump_cur}, 32'h1B);
    chk("R6", {26'd0, sw_out}, 32'h25);
    chk("R11", {31'd0, word_valid}, 32'd1);

    // R1: wrong strap address
    strap = 2'd3; xb[0] = addr_of(2'd0); xb[1] = 8'h00; xn = 2;
    run_xfer(1);

    // R7: control byte first
    strap = 2'd0; xb[0] = addr_of(strap); xb[1] = 8'h84; xb[2] = 8'h3C; xn = 3;
    run_xfer(1);
    chk("R7", {17'd0, scale_word}, 32'h1A95);
    chk("R7", {31'd0, pump_off}, 32'd1);
    chk("R7", {26'd0, sw_out}, 32'h3C);

    // R8/R9: byte after divider 3 with bit7 low
    xb[1] = 8'h07; xb[2] = 8'h3F; xb[3] = 8'h3F; xb[4] = 8'h12; xn = 5;
    run_xfer(1);
    chk("R9", {17'd0, scale_word}, 32'h1A95);

    // R8: control byte 3 with low bits set
    xb[1] = 8'hFF; xb[2] = 8'h00; xb[3] = 8'h81; xn = 4;
    run_xfer(1);
    chk("R9", {30'd0, pump_cur}, 32'd0);

    // R8/R9: extra byte after control byte 3
    xb[1] = 8'h80; xb[2] = 8'hC0; xb[3] = 8'h00; xb[4] = 8'h00; xn = 5;
    run_xfer(1);
    chk("R9", {31'd0, dbl_off}, 32'd0);

    // R14: repeated START drops staged divider bytes
    xb[1] = 8'h00; xb[2] = 8'h00; xn = 3;
    run_xfer(0);
    xb[1] = 8'h81; xn = 2;
    run_xfer(1);
    chk("R14", {17'd0, scale_word}, 32'h1A95);
    chk("R14", {30'd0, pump_cur}, 32'd1);

    // random mix
    for (int t = 0; t < 40; t++) begin
      int st, len;
      strap = 2'($urandom_range(0, 3));
      xb[0] = addr_of(strap);
      if ($urandom_range(0, 7) == 0) xb[0] ^= 8'(1 << $urandom_range(0, 7));
      st = ($urandom_range(0, 1) == 1) ? 0 : 3;
      len = $urandom_range(1, 6 - st);
      for (int j = 0; j < len; j++) xb[1 + j] = gen_byte(st + j);
      xn = 1 + len;
      if (st + len == 6 && $urandom_range(0, 3) == 0) begin
        xb[xn] = 8'($urandom); xn++;
      end
      if ($urandom_range(0, 4) == 0) xb[$urandom_range(1, xn - 1)] ^= 8'(1 << $urandom_range(0, 7));
      run_xfer(1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", ncheck, nbad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      ncheck++; nbad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", ncheck, nbad);
      $finish;
    end
  end
endmodule